// File: doc/BRIEF.md
# Power-Good Strap Latch and Power-Down Sequencer

This block serves a single input pin that changes role during operation. After reset the pin is an active-low power-good indication. The first time the synchronised pin reads low, the block captures two CPU frequency-select straps and a PCIe source-select strap and marks them valid. The capture happens only once. Later changes on the straps or on the pin do not reach the captured values unless test mode is active. While test mode is active, each cycle in which the pin reads low captures the straps again.

Once the straps are valid, the same pin becomes an active-high power-down request. A request is accepted only after the synchronised pin has been high at two consecutive clock edges. The sequencer first parks the output clocks low and holds them there for a programmable number of cycles. It then switches off the oscillator and the PLLs. When the pin drops again, the sequencer turns the sources back on and waits for a synchronised PLL lock. It then counts a short settling interval and enables the outputs.

Top module: `pwrgd_pdn_ctrl`

## Requirements
- R1: While reset is held, and directly after it, straps_valid is 0, clk_out_en is 0, osc_en and pll_en are 1, fs_status is 2'b10, cpu_freq_sel is 0 and pcie_src_sel is 0.
- R2: When the pin falls with the straps valid flag clear, the flag is still 0 after SYNC_STAGES clock edges and is 1 after SYNC_STAGES+1 edges. It then stays 1 until reset.
- R3: cpu_freq_sel decodes the captured fs_strap as follows: 2'b10 gives code 0 (100 MHz), 2'b00 gives code 1 (133 MHz), 2'b01 gives code 2 (166 MHz) and 2'b11 gives code 3 (200 MHz). fs_status reads back the captured bits.
- R4: pcie_src_strap is captured into pcie_src_sel by the same event that captures fs_strap.
- R5: Once straps_valid is 1 and test_mode is 0, fs_status and pcie_src_sel do not change, whatever the straps or the pin do.
- R6: With test_mode at 1, the straps are captured again at the next edge in every cycle in which the synchronised pin is low. A high pin does not start a power-down while test_mode is 1.
- R7: A power-down request needs the synchronised pin high at two consecutive edges. A high pulse of one cycle leaves clk_out_en at 1.
- R8: After a rising pin edge in run mode, clk_out_en is still 1 after SYNC_STAGES+1 edges and is 0 after SYNC_STAGES+2 edges. osc_en and pll_en stay at 1 for PARK_CYCLES more edges. clk_out_en is never 1 while a source is off.
- R9: osc_en and pll_en fall together, SYNC_STAGES+2+PARK_CYCLES edges after the request edge, and only after clk_out_en has been 0 for at least one cycle.
- R10: When the pin falls during shutdown, osc_en and pll_en return to 1 after SYNC_STAGES+1 edges. clk_out_en stays 0 for as long as pll_lock stays low.
- R11: After pll_lock rises while the sequencer waits for lock, clk_out_en is 0 after SYNC_STAGES+ENA_CYCLES edges and 1 after SYNC_STAGES+ENA_CYCLES+1 edges.
- R12: At bring-up with pll_lock already high, clk_out_en rises SYNC_STAGES+2+ENA_CYCLES edges after the first power-good fall, and only while straps_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock that samples the pin |
| rst_n | input | 1 | Full asynchronous reset, active low |
| pwrgd_pdn_in | input | 1 | Dual-role pin: power-good (low) first, power-down request (high) afterwards |
| fs_strap | input | 2 | CPU frequency-select straps |
| pcie_src_strap | input | 1 | PCIe source-select strap |
| test_mode | input | 1 | Allows re-capture of the straps and blocks power-down |
| pll_lock | input | 1 | Asynchronous PLL lock indication |
| straps_valid | output | 1 | Straps have been captured |
| fs_status | output | 2 | Captured frequency-select bits |
| cpu_freq_sel | output | 2 | Decoded CPU frequency code |
| pcie_src_sel | output | 1 | Captured PCIe source select |
| clk_out_en | output | 1 | Output clocks run (0 = parked low) |
| osc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |

## Verification
The bench builds the block with SYNC_STAGES=3, ENA_CYCLES=3 and PARK_CYCLES=5, all different from the defaults. A latency error in the synchroniser, the park hold or the settling count therefore moves an edge by a cycle that the scoreboard expects. Because the park hold is longer than the settling interval, the checks on the source shutdown cannot be met by an exchanged counter limit. The bench walks all four strap codes in test mode and then locks them. It sends a single-cycle pin pulse and runs a full power-down and wake-up with a delayed lock.

// File: rtl/pgpd_pkg.sv
package pgpd_pkg;

    typedef enum logic [2:0] {
        SEQ_RUN       = 3'd0,
        SEQ_PARK      = 3'd1,
        SEQ_SHUTDOWN  = 3'd2,
        SEQ_WAIT_LOCK = 3'd3,
        SEQ_ENABLE    = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        CPU_F100 = 2'd0,
        CPU_F133 = 2'd1,
        CPU_F166 = 2'd2,
        CPU_F200 = 2'd3
    } cpu_freq_e;

    typedef struct packed {
        logic       valid;
        logic [1:0] fs;
        logic       pcie_sel;
    } strap_regs_t;

    // Strap pattern to CPU frequency code
    function automatic cpu_freq_e decode_fs(input logic [1:0] fs);
        cpu_freq_e f;
        unique case (fs)
            2'b10:   f = CPU_F100;
            2'b00:   f = CPU_F133;
            2'b01:   f = CPU_F166;
            default: f = CPU_F200;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/pgpd_sync.sv
module pgpd_sync #(
    parameter int unsigned       WIDTH   = 1,
    parameter int unsigned       STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/pgpd_strap_latch.sv
module pgpd_strap_latch
    import pgpd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pin_s,
    input  logic        test_mode,
    input  logic [1:0]  fs_raw,
    input  logic        pcie_raw,
    output strap_regs_t regs
);

    localparam strap_regs_t RESET_REGS = '{valid: 1'b0, fs: 2'b10, pcie_sel: 1'b0};

    strap_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        // power-good is active low; capture once, or again under test mode
        if (!pin_s && (!regs_q.valid || test_mode)) begin
            regs_d.valid    = 1'b1;
            regs_d.fs       = fs_raw;
            regs_d.pcie_sel = pcie_raw;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= RESET_REGS;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs = regs_q;

endmodule

// File: rtl/pgpd_seq.sv
module pgpd_seq
    import pgpd_pkg::*;
#(
    parameter int unsigned ENA_CYCLES  = 4,
    parameter int unsigned PARK_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_s,
    input  logic       lock_s,
    input  logic       test_mode,
    input  logic       straps_valid,
    output logic       out_en,
    output logic       src_en,
    output seq_state_e state
);

    localparam int unsigned MAX_CNT = (ENA_CYCLES > PARK_CYCLES) ? ENA_CYCLES : PARK_CYCLES;
    localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] ENA_LAST  = CNT_W'(ENA_CYCLES - 1);
    localparam logic [CNT_W-1:0] PARK_LAST = CNT_W'(PARK_CYCLES - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             pin_prev;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;
    logic      pd_hit;

    // request seen high on this edge and the one before
    assign pd_hit = straps_valid && !test_mode && pin_s && seq_q.pin_prev;

    always_comb begin
        seq_d          = seq_q;
        seq_d.pin_prev = pin_s;
        unique case (seq_q.state)
            SEQ_RUN: begin
                if (pd_hit) begin
                    seq_d.state = SEQ_PARK;
                    seq_d.cnt   = '0;
                end
            end
            SEQ_PARK: begin
                if (seq_q.cnt == PARK_LAST) begin
                    seq_d.state = SEQ_SHUTDOWN;
                    seq_d.cnt   = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            SEQ_SHUTDOWN: begin
                if (!pin_s) begin
                    seq_d.state = SEQ_WAIT_LOCK;
                end
            end
            SEQ_WAIT_LOCK: begin
                if (pd_hit) begin
                    seq_d.state = SEQ_PARK;
                    seq_d.cnt   = '0;
                end else if (lock_s && straps_valid) begin
                    seq_d.state = SEQ_ENABLE;
                    seq_d.cnt   = '0;
                end
            end
            SEQ_ENABLE: begin
                if (pd_hit) begin
                    seq_d.state = SEQ_PARK;
                    seq_d.cnt   = '0;
                end else if (!lock_s) begin
                    seq_d.state = SEQ_WAIT_LOCK;
                end else if (seq_q.cnt == ENA_LAST) begin
                    seq_d.state = SEQ_RUN;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d.state = SEQ_WAIT_LOCK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: SEQ_WAIT_LOCK, cnt: '0, pin_prev: 1'b1};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state  = seq_q.state;
    assign out_en = (seq_q.state == SEQ_RUN);
    assign src_en = (seq_q.state != SEQ_SHUTDOWN);

endmodule

// File: rtl/pwrgd_pdn_ctrl.sv
module pwrgd_pdn_ctrl
    import pgpd_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ENA_CYCLES  = 4,
    parameter int unsigned PARK_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwrgd_pdn_in,
    input  logic [1:0] fs_strap,
    input  logic       pcie_src_strap,
    input  logic       test_mode,
    input  logic       pll_lock,
    output logic       straps_valid,
    output logic [1:0] fs_status,
    output logic [1:0] cpu_freq_sel,
    output logic       pcie_src_sel,
    output logic       clk_out_en,
    output logic       osc_en,
    output logic       pll_en
);

    logic        pin_s;
    logic        lock_s;
    logic        src_en;
    strap_regs_t straps;
    seq_state_e  seq_state;

    // pin idles high (no power-good yet), lock idles low
    pgpd_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b01)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({pll_lock, pwrgd_pdn_in}),
        .q     ({lock_s, pin_s})
    );

    pgpd_strap_latch u_straps (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_s     (pin_s),
        .test_mode (test_mode),
        .fs_raw    (fs_strap),
        .pcie_raw  (pcie_src_strap),
        .regs      (straps)
    );

    pgpd_seq #(
        .ENA_CYCLES  (ENA_CYCLES),
        .PARK_CYCLES (PARK_CYCLES)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_s        (pin_s),
        .lock_s       (lock_s),
        .test_mode    (test_mode),
        .straps_valid (straps.valid),
        .out_en       (clk_out_en),
        .src_en       (src_en),
        .state        (seq_state)
    );

    assign straps_valid = straps.valid;
    assign fs_status    = straps.fs;
    assign cpu_freq_sel = decode_fs(straps.fs);
    assign pcie_src_sel = straps.pcie_sel;
    assign osc_en       = src_en;
    assign pll_en       = src_en;

endmodule

// File: rtl/pwrgd_pdn_ctrl_chk.sv
module pwrgd_pdn_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       test_mode,
    input logic       pin_s,
    input logic       lock_s,
    input logic       straps_valid,
    input logic [1:0] fs_status,
    input logic       pcie_src_sel,
    input logic       clk_out_en,
    input logic       osc_en,
    input logic       pll_en
);

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        straps_valid |=> straps_valid); // R2

    AST_STRAPS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (straps_valid && !test_mode) |=> ($stable(fs_status) && $stable(pcie_src_sel))); // R5

    AST_TWO_HIGH_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_out_en) |-> ($past(pin_s) && $past(pin_s, 2) && !$past(test_mode))); // R7

    AST_OUT_NEEDS_SOURCES: assert property (@(posedge clk) disable iff (!rst_n)
        clk_out_en |-> (osc_en && pll_en)); // R8

    AST_PARK_BEFORE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en) |-> !$past(clk_out_en)); // R9

    AST_EN_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_out_en) |-> ($past(lock_s) && straps_valid)); // R11

endmodule

bind pwrgd_pdn_ctrl pwrgd_pdn_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .test_mode    (test_mode),
    .pin_s        (pin_s),
    .lock_s       (lock_s),
    .straps_valid (straps_valid),
    .fs_status    (fs_status),
    .pcie_src_sel (pcie_src_sel),
    .clk_out_en   (clk_out_en),
    .osc_en       (osc_en),
    .pll_en       (pll_en)
);

// File: tb/pwrgd_pdn_ctrl_tb.sv
module pwrgd_pdn_ctrl_tb;

    localparam int S = 3;
    localparam int E = 3;
    localparam int P = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin = 1'b1;
    logic [1:0] fs = 2'b01;
    logic       pcs = 1'b1;
    logic       tmode = 1'b0;
    logic       lock = 1'b1;
    logic       straps_valid, pcie_src_sel, clk_out_en, osc_en, pll_en;
    logic [1:0] fs_status, cpu_freq_sel;

    pwrgd_pdn_ctrl #(.SYNC_STAGES(S), .ENA_CYCLES(E), .PARK_CYCLES(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwrgd_pdn_in(pin), .fs_strap(fs),
        .pcie_src_strap(pcs), .test_mode(tmode), .pll_lock(lock),
        .straps_valid(straps_valid), .fs_status(fs_status), .cpu_freq_sel(cpu_freq_sel),
        .pcie_src_sel(pcie_src_sel), .clk_out_en(clk_out_en), .osc_en(osc_en), .pll_en(pll_en)
    );

    always #10 clk = ~clk;

    typedef struct {
        int         cyc;
        logic [8:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];
    int    cyc_cnt = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    logic [1:0] cur_fs;
    logic       cur_pc;

    always @(posedge clk) cyc_cnt = cyc_cnt + 1;

    // independent model of the frequency code (R3)
    function automatic logic [1:0] ref_code(input logic [1:0] f);
        if (f == 2'b10) return 2'd0;
        if (f == 2'b00) return 2'd1;
        if (f == 2'b01) return 2'd2;
        return 2'd3;
    endfunction

    function automatic logic [8:0] mk(input logic v, input logic [1:0] f, input logic pc,
                                      input logic oe, input logic src);
        return {v, f, ref_code(f), pc, oe, src, src};
    endfunction

    task automatic expect_at(input int lat, input logic [8:0] e, input string tag);
        item_t it;
        int pos;
        it.cyc = cyc_cnt + lat;
        it.exp = e;
        it.tag = tag;
        pos = sb_q.size();
        for (int i = 0; i < sb_q.size(); i++) begin
            if (sb_q[i].cyc > it.cyc) begin
                pos = i;
                break;
            end
        end
        sb_q.insert(pos, it);
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // monitor: compares away from the active edge
    always @(negedge clk) begin
        logic [8:0] act;
        act = {straps_valid, fs_status, cpu_freq_sel, pcie_src_sel, clk_out_en, osc_en, pll_en};
        while (sb_q.size() > 0 && sb_q[0].cyc <= cyc_cnt) begin
            checks++;
            if (sb_q[0].cyc < cyc_cnt || act !== sb_q[0].exp) begin
                errors++;
                $display("FAIL %s: actual %b expected %b", sb_q[0].tag, act, sb_q[0].exp);
            end
            void'(sb_q.pop_front());
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        expect_at(0, mk(1'b0, 2'b10, 1'b0, 1'b0, 1'b1), "R1 during reset");
        tick(1);
        rst_n = 1'b1;
        tick(1);
        expect_at(0, mk(1'b0, 2'b10, 1'b0, 1'b0, 1'b1), "R1 after reset");
        tick(2);

        // first power-good: capture fs=01, pcie=1 (R2 R3 R4 R12)
        pin = 1'b0;
        cur_fs = 2'b01;
        cur_pc = 1'b1;
        expect_at(S, mk(1'b0, 2'b10, 1'b0, 1'b0, 1'b1), "R2 not yet valid");
        expect_at(S + 1, mk(1'b1, cur_fs, cur_pc, 1'b0, 1'b1), "R2 R4 capture");
        expect_at(S + 1 + E, mk(1'b1, cur_fs, cur_pc, 1'b0, 1'b1), "R12 still parked");
        expect_at(S + 2 + E, mk(1'b1, cur_fs, cur_pc, 1'b1, 1'b1), "R12 outputs on");
        tick(S + E + 8);

        // strap change and one-cycle pulse: ignored (R5 R7)
        fs = 2'b00;
        pcs = 1'b0;
        tick(2);
        pin = 1'b1;
        tick(1);
        pin = 1'b0;
        for (int i = 1; i <= S + 4; i++) begin
            expect_at(i, mk(1'b1, cur_fs, cur_pc, 1'b1, 1'b1), "R5 R7 pulse ignored");
        end
        tick(S + 6);

        // test mode: every code re-captured (R6 R3)
        tmode = 1'b1;
        for (int k = 0; k < 4; k++) begin
            logic [1:0] codes [4];
            codes = '{2'b10, 2'b00, 2'b11, 2'b01};
            fs = codes[k];
            pcs = k[0];
            cur_fs = codes[k];
            cur_pc = k[0];
            expect_at(1, mk(1'b1, cur_fs, cur_pc, 1'b1, 1'b1), "R6 R3 test recapture");
            tick(3);
        end
        pin = 1'b1;
        for (int i = 1; i <= S + 6; i++) begin
            expect_at(i, mk(1'b1, cur_fs, cur_pc, 1'b1, 1'b1), "R6 no power-down in test");
        end
        tick(S + 7);
        pin = 1'b0;
        tick(S + 2);
        tmode = 1'b0;
        tick(1);
        fs = 2'b00;
        pcs = 1'b0;
        expect_at(2, mk(1'b1, cur_fs, cur_pc, 1'b1, 1'b1), "R5 locked after test");
        tick(4);

        // power-down: park then shutdown (R8 R9)
        pin = 1'b1;
        expect_at(S + 1, mk(1'b1, cur_fs, cur_pc, 1'b1, 1'b1), "R8 still running");
        expect_at(S + 2, mk(1'b1, cur_fs, cur_pc, 1'b0, 1'b1), "R8 parked");
        expect_at(S + 1 + P, mk(1'b1, cur_fs, cur_pc, 1'b0, 1'b1), "R8 sources held");
        expect_at(S + 2 + P, mk(1'b1, cur_fs, cur_pc, 1'b0, 1'b0), "R9 sources off");
        tick(S + P + 3);
        lock = 1'b0;
        tick(4);

        // release: sources back, outputs wait for lock (R10 R11)
        pin = 1'b0;
        expect_at(S, mk(1'b1, cur_fs, cur_pc, 1'b0, 1'b0), "R10 still off");
        expect_at(S + 1, mk(1'b1, cur_fs, cur_pc, 1'b0, 1'b1), "R10 sources on");
        tick(S + 8);
        expect_at(0, mk(1'b1, cur_fs, cur_pc, 1'b0, 1'b1), "R10 wait for lock");
        tick(1);
        lock = 1'b1;
        expect_at(S + E, mk(1'b1, cur_fs, cur_pc, 1'b0, 1'b1), "R11 settling");
        expect_at(S + E + 1, mk(1'b1, cur_fs, cur_pc, 1'b1, 1'b1), "R11 outputs on");
        tick(S + E + 6);

        while (sb_q.size() > 0) tick(1);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule